// File: doc/BRIEF.md
# Nibble Rotate Through Memory Unit

This unit carries out the two decimal-digit rotate operations that move four-bit digits between the accumulator and one byte of memory. The accumulator's low digit, the memory byte's high digit and the memory byte's low digit form a 12-bit ring of three digits. Each operation turns this ring one digit to the right or one digit to the left. The accumulator's high digit is left as it was. The unit reads the byte at the supplied address, works out the new memory byte and the new accumulator, writes the byte back to the same address and produces a new flag byte.

An operation request comes in on a valid/ready handshake. The request carries the direction, the accumulator, the current flags and the address. `req_ready` is high only while the unit is idle, so the requester has to hold its request until `req_ready` goes high. Any `req_valid` seen while the unit is busy is ignored and the captured operands are not disturbed.

The memory port is synchronous. Read data appears on `mem_rdata` in the cycle after `mem_rd`. The write is issued one cycle after the read data has been captured. `done` pulses for one cycle after the write, and the new accumulator and flags are valid from that cycle on. They are held until the next operation completes.

Top module: `nrot_unit`

## Requirements
- R1: A request is taken when `req_valid` and `req_ready` are both high. `req_ready` is high only in the idle state. While an operation is in progress, `req_valid` and the operand inputs have no effect on that operation's results.
- R2: In the cycle after a request is taken, `mem_rd` is high for one cycle and `mem_addr` equals the request address.
- R3: `mem_wr` is high for exactly one cycle, two cycles after `mem_rd`, and at the same address. No two of `mem_rd`, `mem_wr` and `done` are ever high together.
- R4: Right rotate (`req_left`=0): the written byte is {old accumulator bits 3:0, old memory bits 7:4}.
- R5: Right rotate: the new accumulator is {old accumulator bits 7:4, old memory bits 3:0}.
- R6: Left rotate (`req_left`=1): the written byte is {old memory bits 3:0, old accumulator bits 3:0}.
- R7: Left rotate: the new accumulator is {old accumulator bits 7:4, old memory bits 7:4}.
- R8: The new flags are taken from the new accumulator as follows:
  - bit 7 (sign) is accumulator bit 7;
  - bit 6 (zero) is 1 when the accumulator is 0;
  - bits 5 and 3 copy accumulator bits 5 and 3;
  - bit 2 (parity) is 1 when the accumulator has an even number of ones.
- R9: In the new flags, bit 4 (half-carry) and bit 1 (subtract) are 0. Bit 0 (carry) equals bit 0 of the request's flags.
- R10: `done` is high for one cycle, in the cycle right after `mem_wr`. `acc_out` and `flags_out` hold the new values from that cycle until the next `done`.
- R11: After reset `req_ready` is 1, `mem_rd`, `mem_wr` and `done` are 0, and `acc_out` and `flags_out` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Operation request present |
| req_ready | output | 1 | Unit idle and able to take a request |
| req_left | input | 1 | 1 = left digit rotate, 0 = right digit rotate |
| req_acc | input | 8 | Accumulator before the operation |
| req_flags | input | 8 | Flag byte before the operation |
| req_addr | input | ADDR_W | Address of the memory operand |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_addr | output | ADDR_W | Memory address |
| mem_wdata | output | 8 | Byte to write |
| mem_rdata | input | 8 | Read data, valid the cycle after `mem_rd` |
| done | output | 1 | Operation complete pulse |
| acc_out | output | 8 | Accumulator after the operation |
| flags_out | output | 8 | Flags after the operation |

## Verification
The assertions assume the following about the environment:
- the memory returns read data exactly one cycle after `mem_rd`;
- the requester does not expect a request to be taken while `req_ready` is low.

The stimulus keeps to these assumptions:
- a bench memory model answers every read on the following edge;
- requests are presented only when the unit is idle, except for deliberate noise requests that are raised during busy cycles and dropped before the unit returns to idle.

Random directions, operands and addresses are mixed with directed cases: all-zero operands, a result of zero, odd and even parity, and carry set and clear.

// File: rtl/nrot_pkg.sv
package nrot_pkg;
  localparam int BYTE_W = 8;
  localparam int NIB_W  = BYTE_W / 2;

  localparam int FL_S = 7;
  localparam int FL_Z = 6;
  localparam int FL_5 = 5;
  localparam int FL_H = 4;
  localparam int FL_3 = 3;
  localparam int FL_P = 2;
  localparam int FL_N = 1;
  localparam int FL_C = 0;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ,
    ST_CAPT,
    ST_WRITE,
    ST_DONE
  } nrot_state_e;
endpackage

// File: rtl/nrot_calc.sv
module nrot_calc
  import nrot_pkg::*;
(
  input  logic              left,
  input  logic [BYTE_W-1:0] acc,
  input  logic              carry,
  input  logic [BYTE_W-1:0] mbyte,
  output logic [BYTE_W-1:0] new_mem,
  output logic [BYTE_W-1:0] new_acc,
  output logic [BYTE_W-1:0] new_flags
);
  logic [NIB_W-1:0] a_lo, a_hi, m_lo, m_hi;

  assign a_lo = acc[NIB_W-1:0];
  assign a_hi = acc[BYTE_W-1:NIB_W];
  assign m_lo = mbyte[NIB_W-1:0];
  assign m_hi = mbyte[BYTE_W-1:NIB_W];

  always_comb begin
    if (left) begin
      new_mem = {m_lo, a_lo};
      new_acc = {a_hi, m_hi};
    end else begin
      new_mem = {a_lo, m_hi};
      new_acc = {a_hi, m_lo};
    end
  end

  always_comb begin
    new_flags       = '0;
    new_flags[FL_S] = new_acc[BYTE_W-1];
    new_flags[FL_Z] = (new_acc == '0);
    new_flags[FL_5] = new_acc[5];
    new_flags[FL_3] = new_acc[3];
    new_flags[FL_P] = ~^new_acc;
    new_flags[FL_H] = 1'b0;
    new_flags[FL_N] = 1'b0;
    new_flags[FL_C] = carry;
  end
endmodule

// File: rtl/nrot_ctrl.sv
module nrot_ctrl
  import nrot_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  output logic req_ready,
  output logic take,
  output logic capture,
  output logic commit,
  output logic mem_rd,
  output logic mem_wr,
  output logic done
);
  nrot_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (req_valid) state_d = ST_READ;
      ST_READ:  state_d = ST_CAPT;
      ST_CAPT:  state_d = ST_WRITE;
      ST_WRITE: state_d = ST_DONE;
      ST_DONE:  state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign req_ready = (state_q == ST_IDLE);
  assign take      = req_ready && req_valid;
  assign mem_rd    = (state_q == ST_READ);
  assign capture   = (state_q == ST_CAPT);
  assign mem_wr    = (state_q == ST_WRITE);
  assign commit    = mem_wr;
  assign done      = (state_q == ST_DONE);
endmodule

// File: rtl/nrot_unit.sv
module nrot_unit
  import nrot_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_left,
  input  logic [BYTE_W-1:0] req_acc,
  input  logic [BYTE_W-1:0] req_flags,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [BYTE_W-1:0] mem_wdata,
  input  logic [BYTE_W-1:0] mem_rdata,
  output logic              done,
  output logic [BYTE_W-1:0] acc_out,
  output logic [BYTE_W-1:0] flags_out
);
  logic              take, capture, commit;
  logic              left_q, carry_q;
  logic [BYTE_W-1:0] acc_q, mbuf_q;
  logic [ADDR_W-1:0] addr_q;
  logic [BYTE_W-1:0] calc_mem, calc_acc, calc_flags;

  nrot_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .take      (take),
    .capture   (capture),
    .commit    (commit),
    .mem_rd    (mem_rd),
    .mem_wr    (mem_wr),
    .done      (done)
  );

  // operand latch: loaded only on an accepted request
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      left_q  <= 1'b0;
      carry_q <= 1'b0;
      acc_q   <= '0;
      addr_q  <= '0;
    end else if (take) begin
      left_q  <= req_left;
      carry_q <= req_flags[FL_C];
      acc_q   <= req_acc;
      addr_q  <= req_addr;
    end
  end

  // memory byte captured the cycle after the read strobe
  always_ff @(posedge clk) begin
    if (!rst_n)       mbuf_q <= '0;
    else if (capture) mbuf_q <= mem_rdata;
  end

  nrot_calc u_calc (
    .left      (left_q),
    .acc       (acc_q),
    .carry     (carry_q),
    .mbyte     (mbuf_q),
    .new_mem   (calc_mem),
    .new_acc   (calc_acc),
    .new_flags (calc_flags)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_out   <= '0;
      flags_out <= '0;
    end else if (commit) begin
      acc_out   <= calc_acc;
      flags_out <= calc_flags;
    end
  end

  assign mem_addr  = addr_q;
  assign mem_wdata = calc_mem;
endmodule

// File: rtl/nrot_chk.sv
module nrot_chk
  import nrot_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              mem_rd,
  input logic              mem_wr,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              done,
  input logic [BYTE_W-1:0] acc_out,
  input logic [BYTE_W-1:0] flags_out
);
  // R2
  accept_reads_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (mem_rd && !req_ready));

  // R3
  read_then_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |-> ##2 (mem_wr && mem_addr == $past(mem_addr, 2)));

  // R3
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mem_rd, mem_wr, done}));

  // R10
  write_then_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |=> (done && !mem_wr));

  // R9
  cleared_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (flags_out[FL_H] == 1'b0 && flags_out[FL_N] == 1'b0));

  // R8
  zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (flags_out[FL_Z] == (acc_out == '0)));

  // R10
  hold_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!done && !$past(mem_wr)) |-> ($stable(acc_out) && $stable(flags_out)));
endmodule

bind nrot_unit nrot_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .mem_rd    (mem_rd),
  .mem_wr    (mem_wr),
  .mem_addr  (mem_addr),
  .done      (done),
  .acc_out   (acc_out),
  .flags_out (flags_out)
);

// File: tb/sim_nrot_unit.sv
module sim_nrot_unit;
  localparam int AW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic          req_left = 1'b0;
  logic [7:0]    req_acc = '0;
  logic [7:0]    req_flags = '0;
  logic [AW-1:0] req_addr = '0;
  logic          mem_rd, mem_wr, done;
  logic [AW-1:0] mem_addr;
  logic [7:0]    mem_wdata, acc_out, flags_out;
  logic [7:0]    mem_rdata = '0;
  logic [7:0]    mem [256];

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  nrot_unit #(.ADDR_W(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_left(req_left), .req_acc(req_acc), .req_flags(req_flags),
    .req_addr(req_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .done(done), .acc_out(acc_out), .flags_out(flags_out)
  );

  always @(posedge clk) begin
    if (mem_rd) mem_rdata <= mem[mem_addr[7:0]];
    if (mem_wr) mem[mem_addr[7:0]] <= mem_wdata;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_mem(input logic l, input logic [7:0] a, input logic [7:0] m);
    return l ? {m[3:0], a[3:0]} : {a[3:0], m[7:4]};
  endfunction

  function automatic logic [7:0] exp_acc(input logic l, input logic [7:0] a, input logic [7:0] m);
    return l ? {a[7:4], m[7:4]} : {a[7:4], m[3:0]};
  endfunction

  function automatic logic [7:0] exp_flags(input logic [7:0] a, input logic c);
    logic p;
    p = 1'b1;
    for (int i = 0; i < 8; i++) p = p ^ a[i];
    return {a[7], (a == 8'h00), a[5], 1'b0, a[3], p, 1'b0, c};
  endfunction

  task automatic run_op(input logic l, input logic [7:0] a, input logic [7:0] f,
                        input logic [AW-1:0] ad, input logic [7:0] m, input logic noise);
    logic [7:0] em, ea, ef;
    em = exp_mem(l, a, m);
    ea = exp_acc(l, a, m);
    ef = exp_flags(ea, f[0]);
    @(negedge clk);
    mem[ad[7:0]] = m;
    req_valid = 1'b1; req_left = l; req_acc = a; req_flags = f; req_addr = ad;
    @(negedge clk);
    chk("R2 read strobe", mem_rd, 1);
    chk("R2 read address", mem_addr, ad);
    chk("R1 busy not ready", req_ready, 0);
    if (noise) begin
      req_valid = 1'b1; req_left = ~l; req_acc = ~a; req_flags = ~f; req_addr = ad ^ 16'h0055;
    end else req_valid = 1'b0;
    @(negedge clk);
    chk("R3 no strobe in capture cycle", {mem_rd, mem_wr, done}, 0);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R3 write strobe", mem_wr, 1);
    chk("R3 write address", mem_addr, ad);
    chk(l ? "R6 left memory byte" : "R4 right memory byte", mem_wdata, em);
    @(negedge clk);
    chk("R10 done pulse", {done, mem_wr}, 2'b10);
    chk(l ? "R7 left accumulator" : "R5 right accumulator", acc_out, ea);
    chk("R8 flags from accumulator", flags_out & 8'hED, ef & 8'hED);
    chk("R9 half-carry subtract carry", flags_out & 8'h13, ef & 8'h13);
    chk("R1 memory after noisy busy", mem[ad[7:0]], em);
    @(negedge clk);
    chk("R10 done single cycle", done, 0);
    chk("R10 accumulator held", acc_out, ea);
    chk("R1 ready again", req_ready, 1);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20250611));
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R11 reset state
    chk("R11 ready after reset", req_ready, 1);
    chk("R11 strobes after reset", {mem_rd, mem_wr, done}, 0);
    chk("R11 outputs after reset", {acc_out, flags_out}, 0);
    rst_n = 1'b1;
    // directed corners
    run_op(1'b0, 8'h12, 8'h00, 16'h0010, 8'h34, 1'b0);
    run_op(1'b1, 8'h12, 8'hFF, 16'h0020, 8'h34, 1'b0);
    run_op(1'b0, 8'h00, 8'h01, 16'h0030, 8'h00, 1'b0);
    run_op(1'b1, 8'h0F, 8'h00, 16'h0040, 8'h0F, 1'b0);
    run_op(1'b0, 8'hA5, 8'hFE, 16'h0050, 8'h7E, 1'b1);
    run_op(1'b1, 8'h3C, 8'h01, 16'h1234, 8'hC3, 1'b1);
    run_op(1'b0, 8'h81, 8'h00, 16'hFFFF, 8'h07, 1'b0);
    // random
    for (int n = 0; n < 300; n++) begin
      run_op(1'($urandom), 8'($urandom), 8'($urandom), AW'($urandom),
             8'($urandom), 1'($urandom_range(0, 3) == 0));
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule